// File: doc/BRIEF.md
# NAND Page ECC Engine

This block builds a 24-bit error-correcting signature over a 512-byte data section while the bytes stream past, one byte per accepted cycle, on their way into or out of a NAND page. During a page write, the finished signature is handed out so that it can be stored in the spare area of the page. During a page read, the signature is built again and combined with the copy that was stored. The block then reports one of four outcomes: the data is clean, one data bit was flipped and can be repaired (with its byte offset and bit index), the stored signature itself is damaged, or the section cannot be corrected.

A section opens on a byte that carries the start marker. The direction (write or read) is taken from `mode_read` on that byte. The section closes after its 512th accepted byte. Idle cycles may fall anywhere inside a section. A section that is cut short produces nothing.

Top module: `nand_ecc_engine`

## Requirements
- R1: The signature holds 12 parity pairs. For pair k in 0..8, bit 2k is the parity of every data bit in bytes whose offset has bit k clear, and bit 2k+1 is the parity of every data bit in bytes whose offset has bit k set. For pair 9+j (j in 0..2), bit 18+2j is the parity of all data bits whose bit index has bit j clear, and bit 19+2j is the parity of those whose bit index has bit j set. `res_sig` carries this signature with every result.
- R2: A section is the byte accepted with `in_sos` high, followed by the next 511 bytes accepted with `in_valid` high. Cycles with `in_valid` low are skipped. `res_valid` is high for exactly one cycle, the cycle after the 512th byte.
- R3: In a write section (`mode_read` low on the start byte), the result has status 0 (clean), byte offset 0 and bit index 0.
- R4: In a read section, the syndrome is `stored_sig` XOR the computed signature. An all-zero syndrome gives status 0.
- R5: In a read section, a syndrome in which every one of the 12 pairs has exactly one bit set gives status 1 (corrected). In that case `res_byte_off` bit k equals syndrome bit 2k+1 for k in 0..8, and `res_bit_idx` bit j equals syndrome bit 19+2j.
- R6: In a read section, a syndrome with exactly one bit set gives status 2 (signature fault, data good), with byte offset 0 and bit index 0.
- R7: Any other non-zero syndrome in a read section gives status 3 (uncorrectable), with byte offset 0 and bit index 0.
- R8: A start marker that arrives before the 512th byte discards the open section and begins a new one. No result is produced for the cut-short section.
- R9: Bytes presented while no section is open and `in_sos` is low are ignored. They produce no result and change no output.
- R10: A synchronous active-low reset clears `res_valid`, `res_sig`, `res_status`, `res_byte_off` and `res_bit_idx` to 0 and abandons any open section.
- R11: `stored_sig` is only sampled together with the 512th byte. Its value at any other time has no effect.
- R12: All result fields hold their value until the next result or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A data byte is presented this cycle |
| in_sos | input | 1 | This byte is the first of a section |
| in_data | input | 8 | Data byte |
| mode_read | input | 1 | Taken on the start byte: 1 read/check, 0 write |
| stored_sig | input | 24 | Signature read from the spare area, needed with the last byte |
| res_valid | output | 1 | One-cycle pulse: result fields updated |
| res_sig | output | 24 | Computed signature of the section |
| res_status | output | 2 | 0 clean, 1 corrected, 2 signature fault, 3 uncorrectable |
| res_byte_off | output | 9 | Offset of the faulty byte when status is 1 |
| res_bit_idx | output | 3 | Index of the faulty bit when status is 1 |

## Verification
The properties assume that `in_sos` is only raised together with `in_valid`, and that `stored_sig` is meaningful in the cycle of the final byte. The clean-match property uses that value through a one-cycle look-back. The bench only raises the start marker on a valid byte. It holds `stored_sig` steady through each read section, except in the one case that deliberately drives a wrong value until the final byte to exercise R11. Idle gaps, cut-short sections, stray bytes and a reset in the middle of a section are all driven at the ports, so every assumed input pattern stays legal.

// File: rtl/nand_ecc_pkg.sv
// Shared constants and types for the NAND page ECC engine.
// Assumes byte-wide data; the column pair count follows from the byte width.
package nand_ecc_pkg;
    localparam int BYTE_W    = 8;
    localparam int COL_PAIRS = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        ECC_CLEAN     = 2'd0,
        ECC_FIXED     = 2'd1,
        ECC_SIG_FAULT = 2'd2,
        ECC_UNCORR    = 2'd3
    } ecc_status_e;
endpackage

// File: rtl/ecc_section_seq.sv
// Section sequencer: tracks whether a section is open and which byte offset
// the current byte takes. Assumes SECTION_BYTES is a power of two, at least 2.
module ecc_section_seq #(
    parameter int SECTION_BYTES = 512,
    parameter int ADDR_W        = $clog2(SECTION_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sos,
    output logic              take,
    output logic              first,
    output logic              last,
    output logic [ADDR_W-1:0] byte_addr
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(SECTION_BYTES - 1);

    logic              open_q;
    logic [ADDR_W-1:0] next_q;

    // Decode the acceptance and the position of the byte on the inputs.
    always_comb begin
        first     = in_valid && in_sos;
        take      = in_valid && (in_sos || open_q);
        byte_addr = in_sos ? '0 : next_q;
        last      = take && (byte_addr == LAST_ADDR);
    end

    // Advance the offset on each accepted byte; close after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            next_q <= '0;
        end else if (take) begin
            if (last) begin
                open_q <= 1'b0;
                next_q <= '0;
            end else begin
                open_q <= 1'b1;
                next_q <= byte_addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ecc_parity_accum.sv
// Parity accumulator: folds each accepted byte into the line-pair and
// column-pair parities. sig_next includes the byte on the inputs, so the
// final signature is available in the cycle of the last byte.
module ecc_parity_accum
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int SIG_W  = 2 * (ADDR_W + COL_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              first,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [BYTE_W-1:0] data,
    output logic [SIG_W-1:0]  sig_next
);
    localparam int COL_BASE = 2 * ADDR_W;

    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] contrib;
    logic             byte_par;

    assign byte_par = ^data;

    // Line pairs: the byte parity lands in the odd or even half of each pair.
    for (genvar k = 0; k < ADDR_W; k++) begin : g_line
        assign contrib[2*k]   = byte_par & ~byte_addr[k];
        assign contrib[2*k+1] = byte_par &  byte_addr[k];
    end

    // Column pairs: split the byte's bits by each bit of their index.
    always_comb begin
        contrib[SIG_W-1:COL_BASE] = '0;
        for (int j = 0; j < COL_PAIRS; j++) begin
            for (int b = 0; b < BYTE_W; b++) begin
                if (((b >> j) & 1) == 1)
                    contrib[COL_BASE+2*j+1] = contrib[COL_BASE+2*j+1] ^ data[b];
                else
                    contrib[COL_BASE+2*j]   = contrib[COL_BASE+2*j]   ^ data[b];
            end
        end
    end

    // Restart on a start byte, otherwise extend the running parities.
    always_comb begin
        if (!take)
            sig_next = sig_q;
        else if (first)
            sig_next = contrib;
        else
            sig_next = sig_q ^ contrib;
    end

    // Hold the running parities between accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sig_q <= '0;
        else if (take)
            sig_q <= sig_next;
    end
endmodule

// File: rtl/ecc_syndrome_decode.sv
// Syndrome decoder: classifies a syndrome as clean, a correctable data bit,
// a damaged signature bit or uncorrectable. Purely combinational.
module ecc_syndrome_decode
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int SIG_W  = 2 * (ADDR_W + COL_PAIRS)
) (
    input  logic [SIG_W-1:0]     syndrome,
    output ecc_status_e          status,
    output logic [ADDR_W-1:0]    byte_off,
    output logic [COL_PAIRS-1:0] bit_idx
);
    localparam int NPAIR = ADDR_W + COL_PAIRS;

    logic [NPAIR-1:0]   pair_one;
    logic [NPAIR-1:0]   odd_bits;
    logic [$clog2(SIG_W+1)-1:0] ones;

    // Each pair with exactly one bit set; the odd bit names the location.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_one[p] = syndrome[2*p] ^ syndrome[2*p+1];
        assign odd_bits[p] = syndrome[2*p+1];
    end

    // Population count of the syndrome.
    always_comb begin
        ones = '0;
        for (int i = 0; i < SIG_W; i++)
            ones = ones + {{($clog2(SIG_W+1)-1){1'b0}}, syndrome[i]};
    end

    // Pick the class; location fields are only meaningful when corrected.
    always_comb begin
        byte_off = '0;
        bit_idx  = '0;
        if (syndrome == '0) begin
            status = ECC_CLEAN;
        end else if (&pair_one) begin
            status   = ECC_FIXED;
            byte_off = odd_bits[ADDR_W-1:0];
            bit_idx  = odd_bits[NPAIR-1:ADDR_W];
        end else if (ones == 1) begin
            status = ECC_SIG_FAULT;
        end else begin
            status = ECC_UNCORR;
        end
    end
endmodule

// File: rtl/nand_ecc_engine.sv
// NAND page ECC engine top: streams one section, builds its signature and,
// on a read, classifies the syndrome against the stored signature.
// Assumes in_sos is only raised with in_valid, and stored_sig is valid with
// the final byte of the section.
module nand_ecc_engine
    import nand_ecc_pkg::*;
#(
    parameter  int SECTION_BYTES = 512,
    localparam int ADDR_W        = $clog2(SECTION_BYTES),
    localparam int SIG_W         = 2 * (ADDR_W + COL_PAIRS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sos,
    input  logic [BYTE_W-1:0]    in_data,
    input  logic                 mode_read,
    input  logic [SIG_W-1:0]     stored_sig,
    output logic                 res_valid,
    output logic [SIG_W-1:0]     res_sig,
    output logic [1:0]           res_status,
    output logic [ADDR_W-1:0]    res_byte_off,
    output logic [COL_PAIRS-1:0] res_bit_idx
);
    logic                 take, first, last;
    logic [ADDR_W-1:0]    byte_addr;
    logic [SIG_W-1:0]     sig_next;
    logic                 mode_q, mode_eff;
    ecc_status_e          dec_status;
    logic [ADDR_W-1:0]    dec_off;
    logic [COL_PAIRS-1:0] dec_bit;

    ecc_section_seq #(
        .SECTION_BYTES(SECTION_BYTES),
        .ADDR_W       (ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sos   (in_sos),
        .take     (take),
        .first    (first),
        .last     (last),
        .byte_addr(byte_addr)
    );

    ecc_parity_accum #(
        .ADDR_W(ADDR_W),
        .SIG_W (SIG_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (first),
        .byte_addr(byte_addr),
        .data     (in_data),
        .sig_next (sig_next)
    );

    ecc_syndrome_decode #(
        .ADDR_W(ADDR_W),
        .SIG_W (SIG_W)
    ) u_dec (
        .syndrome(sig_next ^ stored_sig),
        .status  (dec_status),
        .byte_off(dec_off),
        .bit_idx (dec_bit)
    );

    // Direction in force for the byte on the inputs.
    assign mode_eff = first ? mode_read : mode_q;

    // Latch the direction when a section opens.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (first)
            mode_q <= mode_read;
    end

    // Register the result on the final byte; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_sig      <= '0;
            res_status   <= ECC_CLEAN;
            res_byte_off <= '0;
            res_bit_idx  <= '0;
        end else begin
            res_valid <= last;
            if (last) begin
                res_sig <= sig_next;
                if (mode_eff) begin
                    res_status   <= dec_status;
                    res_byte_off <= dec_off;
                    res_bit_idx  <= dec_bit;
                end else begin
                    res_status   <= ECC_CLEAN;
                    res_byte_off <= '0;
                    res_bit_idx  <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/nand_ecc_checker.sv
// Property checker for nand_ecc_engine, attached by bind below.
module nand_ecc_checker #(
    parameter int ADDR_W = 9,
    parameter int SIG_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sos,
    input logic              mode_read,
    input logic [SIG_W-1:0]  stored_sig,
    input logic              res_valid,
    input logic [SIG_W-1:0]  res_sig,
    input logic [1:0]        res_status,
    input logic [ADDR_W-1:0] res_byte_off,
    input logic [2:0]        res_bit_idx
);
    logic dir_q;

    // Track the direction announced on the last start byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= 1'b0;
        else if (in_valid && in_sos)
            dir_q <= mode_read;
    end

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid));

    p_write_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !dir_q) |-> (res_status == 2'd0 && res_byte_off == '0 && res_bit_idx == '0));

    p_match_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && dir_q && res_sig == $past(stored_sig)) |-> (res_status == 2'd0));

    p_sigfault_loc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'd2) |-> (res_byte_off == '0 && res_bit_idx == '0));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && $past(rst_n)) |-> ($stable(res_sig) && $stable(res_status)
                                          && $stable(res_byte_off) && $stable(res_bit_idx)));

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res_status == 2'd0 && res_sig == '0));
endmodule

bind nand_ecc_engine nand_ecc_checker #(
    .ADDR_W(ADDR_W),
    .SIG_W (SIG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sos      (in_sos),
    .mode_read   (mode_read),
    .stored_sig  (stored_sig),
    .res_valid   (res_valid),
    .res_sig     (res_sig),
    .res_status  (res_status),
    .res_byte_off(res_byte_off),
    .res_bit_idx (res_bit_idx)
);

// File: tb/sim_nand_ecc_engine.sv
module sim_nand_ecc_engine;
    localparam int NB = 512;

    typedef struct packed {
        logic [7:0] seed;
        logic       rd;
        logic       gap;
        logic [1:0] nflip;
        logic [8:0] ba;
        logic [2:0] ia;
        logic [8:0] bb;
        logic [2:0] ib;
        logic       sgf;
        logic [4:0] sgp;
        logic [1:0] est;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h11, 1'b0, 1'b0, 2'd0, 9'd0,   3'd0, 9'd0,   3'd0, 1'b0, 5'd0,  2'd0},
        '{8'h11, 1'b1, 1'b0, 2'd0, 9'd0,   3'd0, 9'd0,   3'd0, 1'b0, 5'd0,  2'd0},
        '{8'h23, 1'b1, 1'b0, 2'd1, 9'd0,   3'd0, 9'd0,   3'd0, 1'b0, 5'd0,  2'd1},
        '{8'h35, 1'b1, 1'b1, 2'd1, 9'd511, 3'd7, 9'd0,   3'd0, 1'b0, 5'd0,  2'd1},
        '{8'h47, 1'b1, 1'b0, 2'd1, 9'd300, 3'd5, 9'd0,   3'd0, 1'b0, 5'd0,  2'd1},
        '{8'h59, 1'b1, 1'b0, 2'd2, 9'd10,  3'd1, 9'd10,  3'd2, 1'b0, 5'd0,  2'd3},
        '{8'h6b, 1'b1, 1'b1, 2'd2, 9'd3,   3'd4, 9'd200, 3'd4, 1'b0, 5'd0,  2'd3},
        '{8'h7d, 1'b1, 1'b0, 2'd0, 9'd0,   3'd0, 9'd0,   3'd0, 1'b1, 5'd7,  2'd2},
        '{8'h8f, 1'b1, 1'b0, 2'd0, 9'd0,   3'd0, 9'd0,   3'd0, 1'b1, 5'd23, 2'd2},
        '{8'h91, 1'b1, 1'b0, 2'd1, 9'd5,   3'd3, 9'd0,   3'd0, 1'b1, 5'd0,  2'd3},
        '{8'ha3, 1'b0, 1'b1, 2'd0, 9'd0,   3'd0, 9'd0,   3'd0, 1'b0, 5'd0,  2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sos = 1'b0, mode_read = 1'b0;
    logic [7:0]  in_data = '0;
    logic [23:0] stored_sig = '0;
    logic        res_valid;
    logic [23:0] res_sig;
    logic [1:0]  res_status;
    logic [8:0]  res_byte_off;
    logic [2:0]  res_bit_idx;

    int checks = 0, errors = 0, pulses = 0;
    bit done = 1'b0;
    logic [7:0] mem [NB];

    always #4 clk = ~clk;

    nand_ecc_engine u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
        .in_data(in_data), .mode_read(mode_read), .stored_sig(stored_sig),
        .res_valid(res_valid), .res_sig(res_sig), .res_status(res_status),
        .res_byte_off(res_byte_off), .res_bit_idx(res_bit_idx)
    );

    always @(negedge clk) if (res_valid) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < NB; i++) mem[i] = 8'((i * 29 + seed * 7) ^ (i >> 3));
    endtask

    // Reference signature built from the pair definitions of R1.
    function automatic logic [23:0] model_sig();
        logic [23:0] s = '0;
        for (int a = 0; a < NB; a++)
            for (int b = 0; b < 8; b++)
                if (mem[a][b]) begin
                    for (int k = 0; k < 9; k++)
                        if (((a >> k) & 1) == 1) s[2*k+1] = ~s[2*k+1]; else s[2*k] = ~s[2*k];
                    for (int j = 0; j < 3; j++)
                        if (((b >> j) & 1) == 1) s[19+2*j] = ~s[19+2*j]; else s[18+2*j] = ~s[18+2*j];
                end
        return s;
    endfunction

    // Drive n bytes from mem; returns at the negedge after the last byte.
    task automatic send(input int n, input bit sos, input bit rd, input bit gap,
                        input logic [23:0] early, input logic [23:0] fin);
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 7 == 3)) begin
                in_valid = 1'b0; in_sos = 1'b0;
                @(negedge clk);
            end
            in_valid   = 1'b1;
            in_sos     = sos && (i == 0);
            mode_read  = rd;
            in_data    = mem[i];
            stored_sig = (i == n - 1) ? fin : early;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sos = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] gold, bad, keep;
        int p0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 valid", 32'(res_valid), 0);
        chk("R10 status", 32'(res_status), 0);
        chk("R10 sig", 32'(res_sig), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            logic [23:0] stored;
            fill(t.seed);
            gold = model_sig();
            if (t.nflip >= 1) mem[t.ba][t.ia] = ~mem[t.ba][t.ia];
            if (t.nflip >= 2) mem[t.bb][t.ib] = ~mem[t.bb][t.ib];
            bad = model_sig();
            stored = gold ^ (t.sgf ? (24'd1 << t.sgp) : 24'd0);
            p0 = pulses;
            send(NB, 1'b1, t.rd, t.gap, stored, stored);
            // R2: pulse visible in the cycle after the final byte
            chk("R2 valid pulse", 32'(res_valid), 1);
            chk("R1 signature", 32'(res_sig), 32'(bad));
            chk(t.rd ? "R4/R5/R6/R7 status" : "R3 status", 32'(res_status), 32'(t.est));
            chk("R5 byte offset", 32'(res_byte_off), (t.est == 2'd1) ? 32'(t.ba) : 0);
            chk("R5 bit index", 32'(res_bit_idx), (t.est == 2'd1) ? 32'(t.ia) : 0);
            @(negedge clk);
            chk("R2 single pulse", 32'(pulses - p0), 1);
            chk("R12 hold", 32'(res_sig), 32'(bad));
        end

        // R8: cut-short section discarded, restart counts from new start byte
        fill(8'h5c);
        gold = model_sig();
        p0 = pulses;
        send(200, 1'b1, 1'b1, 1'b0, gold, gold);
        send(NB, 1'b1, 1'b1, 1'b0, gold, gold);
        chk("R8 status", 32'(res_status), 0);
        chk("R8 sig", 32'(res_sig), 32'(gold));
        @(negedge clk);
        chk("R8 one result", 32'(pulses - p0), 1);

        // R9: stray bytes without a start marker
        keep = res_sig;
        fill(8'hee);
        p0 = pulses;
        send(600, 1'b0, 1'b1, 1'b0, 24'hffffff, 24'h0);
        repeat (2) @(negedge clk);
        chk("R9 no result", 32'(pulses - p0), 0);
        chk("R9 sig unchanged", 32'(res_sig), 32'(keep));
        chk("R9 status unchanged", 32'(res_status), 0);

        // R11: stored signature wrong until the final byte
        fill(8'h3a);
        gold = model_sig();
        send(NB, 1'b1, 1'b1, 1'b1, ~gold, gold);
        chk("R11 valid", 32'(res_valid), 1);
        chk("R11 status", 32'(res_status), 0);
        @(negedge clk);

        // R10: reset mid-section abandons it
        fill(8'h77);
        p0 = pulses;
        send(300, 1'b1, 1'b1, 1'b0, 24'h1, 24'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 cleared sig", 32'(res_sig), 0);
        send(212, 1'b0, 1'b1, 1'b0, 24'h1, 24'h1);
        repeat (2) @(negedge clk);
        chk("R10 no result after reset", 32'(pulses - p0), 0);
        chk("R10 status after reset", 32'(res_status), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule